// File: doc/BRIEF.md
# Sub-Second Real-Time Counter with Dual Alarms

The block keeps absolute time from a 32.768 kHz timebase. A prescaler turns that timebase into a 4096 Hz tick. The tick drives a 12-bit fraction-of-second counter, which carries into a 32-bit seconds count that spans roughly 136 years.

Two alarms run independently of each other:

- The time-of-day alarm watches the seconds count. It can be set from one second to about twelve days ahead.
- The interval alarm counts 1/4096 s ticks with a 32-bit down-counter. It spans from 244 µs to about twelve days.

Each alarm is either single-shot or periodic. Each one sets a sticky flag, which can be routed to an interrupt line, to the wake request, or to both.

A signed trim nudges the effective rate in parts-per-million steps. It does this by skipping or stretching single timebase cycles.

Software drives the block through a write-only register port: a strobe, a 3-bit address and 32 bits of data. The time is always visible on the `seconds_o` and `subsec_o` outputs. None of the ports stream data, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where the strobe is sampled.

Top module: `rtc_subsec_core`

## Requirements
- R1: After reset, `seconds_o` and `subsec_o` are zero, and `tod_irq_o`, `sub_irq_o` and `wake_o` are low.
- R2: With zero trim, `subsec_o` advances by exactly one every PRESC_DIV clock cycles (default 8, giving 4096 Hz from 32.768 kHz) and holds between ticks.
- R3: A tick that finds `subsec_o` at 4095 wraps it to 0 and adds one to `seconds_o`. The seconds count wraps from 0xFFFFFFFF to 0.
- R4: A write to address 0 loads `seconds_o` with the data. The same write clears `subsec_o`, the prescaler phase and the trim accumulator, so the next tick follows PRESC_DIV cycles later.
- R5: The time-of-day alarm is armed by control bit 0. It fires in the cycle where the seconds count advances to a value whose low 20 bits equal the match register (address 1). When periodic mode (control bit 1) is off, firing clears control bit 0, so a later match does nothing.
- R6: With control bit 1 set, each time-of-day firing adds the period register (address 2) to the match value, modulo 2^20, and stays armed.
- R7: The interval alarm down-counter loads from the interval register on a write to address 3, or on a control write (address 4) that sets bit 2. It fires on the N-th following tick for an interval of N, where N = 0 never fires. A single-shot firing clears bit 2, so no further firing happens.
- R8: With control bit 3 set, the interval alarm reloads on firing and fires again every N ticks.
- R9: Each alarm sets a sticky flag. A write to address 6 clears the time-of-day flag with bit 0 and the interval flag with bit 1; a firing in the same cycle wins over the clear. `tod_irq_o` is the time-of-day flag AND control bit 4. `sub_irq_o` is the interval flag AND control bit 6. `wake_o` is the OR of (time-of-day flag AND bit 5) and (interval flag AND bit 7).
- R10: The trim register (address 5) holds a magnitude m in bits 6:0 and a direction in bit 7 (0 = run fast, 1 = run slow). Every TRIM_PERIOD cycles, m cycles either count double (fast) or count zero (slow). A magnitude of 0 leaves the rate unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| seconds_o | output | 32 | Absolute seconds count |
| subsec_o | output | 12 | Fraction of second in 1/4096 s units |
| tod_irq_o | output | 1 | Time-of-day alarm interrupt |
| sub_irq_o | output | 1 | Interval alarm interrupt |
| wake_o | output | 1 | Combined wake request |

## Verification
The situations hardest to reach from the ports are a firing that lands exactly on a 20-bit match while the upper seconds bits are non-zero, and the disarm that follows a single-shot firing. The bench presets the seconds count one step short of the match, with upper bits set, and waits for the carry. It then rewinds the seconds so that the same match recurs and confirms that no flag appears. The trim rate is also hard to observe: the bench shortens the prescaler and accumulation period through parameters, then counts fraction-of-second steps over a fixed window after a seconds write has reset the phase.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SUB_W   = 12;
  localparam int MATCH_W = 20;
  localparam int TRIM_W  = 7;

  localparam logic [2:0] A_SECONDS = 3'd0;
  localparam logic [2:0] A_MATCH   = 3'd1;
  localparam logic [2:0] A_PERIOD  = 3'd2;
  localparam logic [2:0] A_IVAL    = 3'd3;
  localparam logic [2:0] A_CTRL    = 3'd4;
  localparam logic [2:0] A_TRIM    = 3'd5;
  localparam logic [2:0] A_FLAGCLR = 3'd6;

  typedef struct packed {
    logic sub_wake;
    logic sub_irq;
    logic tod_wake;
    logic tod_irq;
    logic sub_rpt;
    logic sub_en;
    logic tod_rpt;
    logic tod_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int PRESC_DIV   = 8,
  parameter int TRIM_PERIOD = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [6:0] mag_i,
  input  logic       slow_i,
  output logic       tick_o
);
  localparam int CW = $clog2(PRESC_DIV + 2) + 1;
  localparam int AW = $clog2(TRIM_PERIOD + 128) + 1;
  localparam logic [CW-1:0] DIV_W = CW'(PRESC_DIV);
  localparam logic [AW-1:0] PER_W = AW'(TRIM_PERIOD);

  logic [CW-1:0] cnt_q, nxt;
  logic [AW-1:0] acc_q, acc_sum;
  logic [1:0]    step;
  logic          adj;

  always_comb begin
    acc_sum = acc_q + AW'(mag_i);
    adj     = (acc_sum >= PER_W);
    if (!adj)        step = 2'd1;
    else if (slow_i) step = 2'd0;
    else             step = 2'd2;
    nxt    = cnt_q + CW'(step);
    tick_o = !clr_i && (nxt >= DIV_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= tick_o ? nxt - DIV_W : nxt;
      acc_q <= adj ? acc_sum - PER_W : acc_sum;
    end
  end

  generate
    if (PRESC_DIV >= 2) begin : g_chk
      AST_ZERO_TRIM_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_i == 7'd0 && tick_o) |=> (!tick_o || mag_i != 7'd0)); // R10
    end
  endgenerate
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper import rtc_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [31:0]        set_i,
  output logic [31:0]        seconds_o,
  output logic [SUB_W-1:0]   subsec_o,
  output logic               sec_step_o,
  output logic [MATCH_W-1:0] sec_next_lo_o
);
  logic [31:0]      sec_q, sec_next;
  logic [SUB_W-1:0] sub_q;
  logic             at_top;

  assign at_top        = &sub_q;
  assign sec_next      = sec_q + 32'd1;
  assign sec_step_o    = tick_i && at_top && !clr_i;
  assign sec_next_lo_o = sec_next[MATCH_W-1:0];
  assign seconds_o     = sec_q;
  assign subsec_o      = sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (clr_i) begin
      sec_q <= set_i;
      sub_q <= '0;
    end else if (tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (at_top) sec_q <= sec_next;
    end
  end

  AST_SUBSEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i) |=> subsec_o == $past(subsec_o) + 1'b1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> ($stable(subsec_o) && $stable(seconds_o))); // R2
  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i && subsec_o == '1) |=> seconds_o == $past(seconds_o) + 32'd1); // R3
endmodule

// File: rtl/rtc_tod_alarm.sv
module rtc_tod_alarm import rtc_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_match_i,
  input  logic [MATCH_W-1:0] match_data_i,
  input  logic [MATCH_W-1:0] period_i,
  input  logic               en_i,
  input  logic               rpt_i,
  input  logic               sec_step_i,
  input  logic [MATCH_W-1:0] sec_next_lo_i,
  output logic               fire_o
);
  logic [MATCH_W-1:0] tgt_q;

  assign fire_o = en_i && sec_step_i && (sec_next_lo_i == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tgt_q <= '0;
    else if (wr_match_i)       tgt_q <= match_data_i;
    else if (fire_o && rpt_i)  tgt_q <= tgt_q + period_i;
  end

  AST_TOD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && rpt_i && !wr_match_i) |=> tgt_q == $past(sec_next_lo_i) + $past(period_i)); // R6
endmodule

// File: rtl/rtc_sub_alarm.sv
module rtc_sub_alarm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        en_i,
  input  logic        rpt_i,
  input  logic        load_i,
  input  logic [31:0] load_val_i,
  input  logic [31:0] ival_i,
  output logic        fire_o
);
  logic [31:0] cnt_q;

  assign fire_o = en_i && tick_i && !load_i && (cnt_q == 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load_i)                     cnt_q <= load_val_i;
    else if (fire_o)                     cnt_q <= rpt_i ? ival_i : 32'd0;
    else if (en_i && tick_i && cnt_q != 32'd0) cnt_q <= cnt_q - 32'd1;
  end

  AST_SUB_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && rpt_i) |=> cnt_q == $past(ival_i)); // R8
endmodule

// File: rtl/rtc_subsec_core.sv
module rtc_subsec_core import rtc_pkg::*; #(
  parameter int PRESC_DIV   = 8,
  parameter int TRIM_PERIOD = 1_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] seconds_o,
  output logic [11:0] subsec_o,
  output logic        tod_irq_o,
  output logic        sub_irq_o,
  output logic        wake_o
);
  ctrl_t              ctrl_q;
  logic [MATCH_W-1:0] period_q;
  logic [31:0]        ival_q;
  logic [7:0]         trim_q;
  logic               tod_flag_q, sub_flag_q;

  logic wr_sec, wr_match, wr_period, wr_ival, wr_ctrl, wr_trim, wr_clr;
  logic tick, sec_step, tod_fire, sub_fire, sub_load;
  logic [MATCH_W-1:0] sec_next_lo;

  assign wr_sec    = wr_en && wr_addr == A_SECONDS;
  assign wr_match  = wr_en && wr_addr == A_MATCH;
  assign wr_period = wr_en && wr_addr == A_PERIOD;
  assign wr_ival   = wr_en && wr_addr == A_IVAL;
  assign wr_ctrl   = wr_en && wr_addr == A_CTRL;
  assign wr_trim   = wr_en && wr_addr == A_TRIM;
  assign wr_clr    = wr_en && wr_addr == A_FLAGCLR;
  assign sub_load  = wr_ival || (wr_ctrl && wr_data[2]);

  rtc_tick_gen #(.PRESC_DIV(PRESC_DIV), .TRIM_PERIOD(TRIM_PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(wr_sec),
    .mag_i(trim_q[TRIM_W-1:0]), .slow_i(trim_q[7]), .tick_o(tick));

  rtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(wr_sec), .set_i(wr_data),
    .seconds_o(seconds_o), .subsec_o(subsec_o),
    .sec_step_o(sec_step), .sec_next_lo_o(sec_next_lo));

  rtc_tod_alarm u_tod (
    .clk(clk), .rst_n(rst_n), .wr_match_i(wr_match),
    .match_data_i(wr_data[MATCH_W-1:0]), .period_i(period_q),
    .en_i(ctrl_q.tod_en), .rpt_i(ctrl_q.tod_rpt),
    .sec_step_i(sec_step), .sec_next_lo_i(sec_next_lo), .fire_o(tod_fire));

  rtc_sub_alarm u_sub (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .en_i(ctrl_q.sub_en), .rpt_i(ctrl_q.sub_rpt),
    .load_i(sub_load), .load_val_i(wr_ival ? wr_data : ival_q),
    .ival_i(ival_q), .fire_o(sub_fire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      period_q   <= '0;
      ival_q     <= '0;
      trim_q     <= '0;
      tod_flag_q <= 1'b0;
      sub_flag_q <= 1'b0;
    end else begin
      if (wr_period) period_q <= wr_data[MATCH_W-1:0];
      if (wr_ival)   ival_q   <= wr_data;
      if (wr_trim)   trim_q   <= wr_data[7:0];
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[7:0]);
      else begin
        if (tod_fire && !ctrl_q.tod_rpt) ctrl_q.tod_en <= 1'b0;
        if (sub_fire && !ctrl_q.sub_rpt) ctrl_q.sub_en <= 1'b0;
      end
      tod_flag_q <= tod_fire || (tod_flag_q && !(wr_clr && wr_data[0]));
      sub_flag_q <= sub_fire || (sub_flag_q && !(wr_clr && wr_data[1]));
    end
  end

  assign tod_irq_o = tod_flag_q && ctrl_q.tod_irq;
  assign sub_irq_o = sub_flag_q && ctrl_q.sub_irq;
  assign wake_o    = (tod_flag_q && ctrl_q.tod_wake) || (sub_flag_q && ctrl_q.sub_wake);

  AST_TOD_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_fire && !ctrl_q.tod_rpt && !wr_ctrl) |=> !ctrl_q.tod_en); // R5
  AST_SUB_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_fire && !ctrl_q.sub_rpt && !wr_ctrl) |=> !ctrl_q.sub_en); // R7
  AST_TOD_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_flag_q && !(wr_clr && wr_data[0])) |=> tod_flag_q); // R9
  AST_SUB_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_flag_q && !(wr_clr && wr_data[1])) |=> sub_flag_q); // R9
endmodule

// File: tb/rtc_subsec_core_tb_top.sv
module rtc_subsec_core_tb_top;
  localparam int DIV = 2;
  localparam int PER = 64;
  localparam int CYC_PER_SEC = DIV * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] seconds_o;
  logic [11:0] subsec_o;
  logic        tod_irq_o, sub_irq_o, wake_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rtc_subsec_core #(.PRESC_DIV(DIV), .TRIM_PERIOD(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seconds_o(seconds_o), .subsec_o(subsec_o),
    .tod_irq_o(tod_irq_o), .sub_irq_o(sub_irq_o), .wake_o(wake_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sec_change();
    logic [31:0] prev = seconds_o;
    for (int i = 0; i < CYC_PER_SEC + 16; i++) begin
      @(negedge clk);
      if (seconds_o != prev) return;
    end
    chk("wait_sec", 32'd0, 32'd1);
  endtask

  task automatic wait_ticks(input logic [11:0] base, input int n);
    for (int i = 0; i < 4 * n + 16; i++) begin
      if (12'(subsec_o - base) == 12'(n)) return;
      @(negedge clk);
    end
    chk("wait_ticks", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 seconds", seconds_o, 32'd0);
    chk("R1 subsec", {20'd0, subsec_o}, 32'd0);
    chk("R1 outputs", {29'd0, tod_irq_o, sub_irq_o, wake_o}, 32'd0);
  endtask

  task automatic t_count();
    wr(3'd0, 32'd5);
    repeat (20) @(negedge clk);
    chk("R2 subsec after 20", {20'd0, subsec_o}, 32'd10);
    @(negedge clk);
    chk("R2 hold between ticks", {20'd0, subsec_o}, 32'd10);
    chk("R2 seconds unchanged", seconds_o, 32'd5);
  endtask

  task automatic t_sec_write();
    wr(3'd0, 32'd5);
    repeat (13) @(negedge clk);
    wr(3'd0, 32'd77);
    chk("R4 seconds loaded", seconds_o, 32'd77);
    chk("R4 subsec cleared", {20'd0, subsec_o}, 32'd0);
    @(negedge clk);
    chk("R4 phase cleared", {20'd0, subsec_o}, 32'd0);
    @(negedge clk);
    chk("R4 first tick", {20'd0, subsec_o}, 32'd1);
  endtask

  task automatic t_wrap();
    wr(3'd0, 32'hFFFF_FFFF);
    repeat (CYC_PER_SEC - 1) @(negedge clk);
    chk("R3 before carry sec", seconds_o, 32'hFFFF_FFFF);
    chk("R3 before carry sub", {20'd0, subsec_o}, 32'd4095);
    @(negedge clk);
    chk("R3 seconds wrap", seconds_o, 32'd0);
    chk("R3 subsec wrap", {20'd0, subsec_o}, 32'd0);
  endtask

  task automatic t_trim();
    wr(3'd5, 32'h08);
    wr(3'd0, 32'd0);
    repeat (640) @(negedge clk);
    chk("R10 fast trim", {20'd0, subsec_o}, 32'd360);
    wr(3'd5, 32'h88);
    wr(3'd0, 32'd0);
    repeat (640) @(negedge clk);
    chk("R10 slow trim", {20'd0, subsec_o}, 32'd280);
    wr(3'd5, 32'h80);
    wr(3'd0, 32'd0);
    repeat (640) @(negedge clk);
    chk("R10 zero trim", {20'd0, subsec_o}, 32'd320);
    wr(3'd5, 32'h00);
  endtask

  task automatic t_tod_oneshot();
    wr(3'd6, 32'd3);
    wr(3'd1, 32'h0000_0006);
    wr(3'd0, 32'h0010_0005);
    wr(3'd4, 32'h11);
    chk("R5 no fire before match", {31'd0, tod_irq_o}, 32'd0);
    wait_sec_change();
    chk("R5 seconds at match", seconds_o, 32'h0010_0006);
    chk("R5 fire on low-bit match", {31'd0, tod_irq_o}, 32'd1);
    chk("R9 wake gated off", {31'd0, wake_o}, 32'd0);
    wr(3'd6, 32'd1);
    chk("R9 flag cleared", {31'd0, tod_irq_o}, 32'd0);
    wr(3'd0, 32'h0010_0005);
    wait_sec_change();
    chk("R5 one-shot disarmed", {31'd0, tod_irq_o}, 32'd0);
  endtask

  task automatic t_tod_repeat();
    wr(3'd6, 32'd3);
    wr(3'd1, 32'd21);
    wr(3'd2, 32'd2);
    wr(3'd0, 32'd20);
    wr(3'd4, 32'h33);
    wait_sec_change();
    chk("R6 first fire", {30'd0, tod_irq_o, wake_o}, 32'd3);
    wr(3'd6, 32'd1);
    wait_sec_change();
    chk("R6 skip between", {30'd0, tod_irq_o, wake_o}, 32'd0);
    wait_sec_change();
    chk("R6 second fire at +period", {30'd0, tod_irq_o, wake_o}, 32'd3);
    wr(3'd4, 32'd0);
    wr(3'd6, 32'd3);
  endtask

  task automatic t_sub_oneshot();
    logic [11:0] base;
    wr(3'd6, 32'd3);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'h44);
    base = subsec_o;
    wait_ticks(base, 4);
    chk("R7 no fire at N-1", {31'd0, sub_irq_o}, 32'd0);
    wait_ticks(base, 5);
    chk("R7 fire at N", {31'd0, sub_irq_o}, 32'd1);
    chk("R9 wake gated off", {31'd0, wake_o}, 32'd0);
    wr(3'd6, 32'd2);
    repeat (30) @(negedge clk);
    chk("R7 one-shot stops", {31'd0, sub_irq_o}, 32'd0);
  endtask

  task automatic t_sub_repeat();
    logic [11:0] base;
    wr(3'd6, 32'd3);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'hCC);
    base = subsec_o;
    wait_ticks(base, 3);
    chk("R8 first fire", {30'd0, sub_irq_o, wake_o}, 32'd3);
    wr(3'd6, 32'd2);
    wait_ticks(base, 5);
    chk("R8 quiet between", {30'd0, sub_irq_o, wake_o}, 32'd0);
    wait_ticks(base, 6);
    chk("R8 refire after reload", {30'd0, sub_irq_o, wake_o}, 32'd3);
    wr(3'd4, 32'd0);
    wr(3'd6, 32'd3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190_000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_sec_write();
    t_trim();
    t_wrap();
    t_tod_oneshot();
    t_tod_repeat();
    t_sub_oneshot();
    t_sub_repeat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule